// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Controller

This block routes up to 24 level-sensitive interrupt request lines to a single vector delivery port. Software reaches its configuration through two bus-visible registers only: an index register that names one internal word, and a data window through which that word is read or written. The internal bank holds an identification word, a read-only version word, an arbitration word and one 64-bit redirection entry per request line. Each entry is split into a low and a high 32-bit half.

In table mode, every pending, unmasked line is looked up in its entry. The line whose programmed vector has the highest upper nibble wins, and that nibble is its priority class. The winning vector is presented on a valid/ready port. In legacy mode, which is the reset default, each line maps to a fixed vector of 0x30 plus its line number, and arbitration follows line order alone. A line that has been delivered is not offered again until its input falls and rises again.

Top module: `irq_router`

## Requirements
- R1: A bus write to byte offset 0x00 stores bits [7:0] of the write data as the window index. A read of offset 0x00 returns that index in bits [7:0], with zeros above.
- R2: Reads and writes at byte offset 0x10 act on the internal word named by the current index. Reads of any other byte offset return zero, and writes there change nothing.
- R3: Index 0 is the identification word. Bits [27:24] are a read/write ID field, and bit 0 is the mode bit (1 = table mode, 0 = legacy mode), which resets to 0. Index 2 is the arbitration word; it reads the ID field in bits [27:24] with zeros elsewhere and ignores writes.
- R4: Index 1 is the version word. It is read-only and reads 0x00170011, with bits [23:16] holding the entry count minus one (23).
- R5: For line n, index 0x10+2n is the low half of its entry: bits [7:0] are the vector and bit 16 is the mask; other bits read zero. Every entry resets to mask=1 and vector=0. Index 0x10+2n+1 (the high half) and every other unlisted index read zero and ignore writes.
- R6: In table mode, a line with its input high and its mask clear is delivered with its programmed vector. A masked line is never delivered.
- R7: dlv_prio always equals dlv_vector[7:4]. In table mode, the highest priority class among eligible lines wins, and ties go to the lowest line number.
- R8: In legacy mode, the vector for line n is 0x30+n, mask bits have no effect, and the lowest eligible line number wins.
- R9: While dlv_valid is high and dlv_ready is low, dlv_valid, dlv_vector and dlv_prio stay unchanged. After a cycle with both high, dlv_valid is low for the following cycle.
- R10: A line that has been delivered is not presented again until its input has been low for at least one clock and then rises.
- R11: When dlv_valid is low and at least one line is eligible at a clock edge, dlv_valid is high with the winner's vector right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the access (0x00 index, 0x10 window) |
| bus_wr | input | 1 | Write strobe for one 32-bit write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | 24 | Level-sensitive request lines |
| dlv_valid | output | 1 | A vector is being offered |
| dlv_ready | input | 1 | The consumer takes the offered vector |
| dlv_vector | output | 8 | Offered interrupt vector |
| dlv_prio | output | 4 | Priority class of the offered vector |

## Verification
The bench sets two lines to vectors of the same class and checks that the lower line number wins; an arbiter that keeps the later match would deliver them in the wrong order. Several lines stay high after being served, and the bench checks that none of them comes back. It then drops one line, raises it again, and checks that only that line returns; a design that tracks levels instead of service state would repeat vectors forever or never repeat them. The bench holds ready low for several cycles to catch a vector that changes under back-pressure. It also writes to the high halves, to unlisted indices and to a stray byte offset, and reads them back as zero, so a decoder that aliases indices shows up as non-zero data or as a changed vector.

// File: rtl/irq_router_pkg.sv
// Shared constants for the interrupt redirection controller.
// Assumes an 8-bit internal index space and 32-bit bus words.
package irq_router_pkg;
    localparam int          IDX_W        = 8;
    localparam int          WORD_W       = 32;
    localparam int          VEC_W        = 8;
    localparam int          PRIO_W       = 4;
    localparam logic [7:0]  IDX_IDENT    = 8'h00;
    localparam logic [7:0]  IDX_VERSION  = 8'h01;
    localparam logic [7:0]  IDX_ARBIT    = 8'h02;
    localparam int          IDX_TBL_BASE = 16;
    localparam logic [7:0]  LEGACY_BASE  = 8'h30;
    localparam int          OFS_SELECT   = 0;
    localparam int          OFS_WINDOW   = 16;
endpackage

// File: rtl/irq_regbank.sv
// Indirect register bank: an index register at OFS_SELECT picks which
// internal word the window at OFS_WINDOW reaches. Holds the mode bit,
// ID field and per-line vector/mask. Assumes NUM_IRQ*2+16 <= 256.
module irq_regbank
    import irq_router_pkg::*;
#(
    parameter int NUM_IRQ = 24,
    parameter int ADDR_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic [WORD_W-1:0]        bus_wdata,
    output logic [WORD_W-1:0]        bus_rdata,
    output logic                     table_mode,
    output logic [NUM_IRQ*VEC_W-1:0] vec_flat,
    output logic [NUM_IRQ-1:0]       mask_vec
);
    localparam logic [WORD_W-1:0] VERSION_WORD = {8'h00, 8'(NUM_IRQ - 1), 8'h00, 8'h11};

    logic [IDX_W-1:0]                sel_q;
    logic [3:0]                      id_q;
    logic                            table_q;
    logic [NUM_IRQ-1:0][VEC_W-1:0]   vec_q;
    logic [NUM_IRQ-1:0]              mask_q;
    logic [WORD_W-1:0]               win_rdata;
    logic                            sel_wr;
    logic                            win_wr;
    logic                            unused_wbits;

    assign sel_wr       = bus_wr && (bus_addr == ADDR_W'(OFS_SELECT));
    assign win_wr       = bus_wr && (bus_addr == ADDR_W'(OFS_WINDOW));
    assign unused_wbits = ^{bus_wdata[31:28], bus_wdata[23:17], bus_wdata[15:8]};

    // Index register, ID field and mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            id_q    <= '0;
            table_q <= 1'b0;
        end else begin
            if (sel_wr) sel_q <= bus_wdata[IDX_W-1:0];
            if (win_wr && sel_q == IDX_IDENT) begin
                id_q    <= bus_wdata[27:24];
                table_q <= bus_wdata[0];
            end
        end
    end

    // One low-half register per line; high halves hold nothing.
    for (genvar n = 0; n < NUM_IRQ; n++) begin : g_entry
        localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(IDX_TBL_BASE + 2 * n);
        // Vector and mask of line n, written through the window.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec_q[n]  <= '0;
                mask_q[n] <= 1'b1;
            end else if (win_wr && sel_q == LO_IDX) begin
                vec_q[n]  <= bus_wdata[VEC_W-1:0];
                mask_q[n] <= bus_wdata[16];
            end
        end
    end

    // Window read mux over the internal index space.
    always_comb begin
        win_rdata = '0;
        if (sel_q == IDX_IDENT)   win_rdata = {4'b0, id_q, 23'b0, table_q};
        if (sel_q == IDX_VERSION) win_rdata = VERSION_WORD;
        if (sel_q == IDX_ARBIT)   win_rdata = {4'b0, id_q, 24'b0};
        for (int n = 0; n < NUM_IRQ; n++) begin
            if (sel_q == IDX_W'(IDX_TBL_BASE + 2 * n))
                win_rdata = {15'b0, mask_q[n], 8'b0, vec_q[n]};
        end
    end

    // Direct bus read mux over the two visible offsets.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_SELECT)) bus_rdata = {{(WORD_W-IDX_W){1'b0}}, sel_q};
        if (bus_addr == ADDR_W'(OFS_WINDOW)) bus_rdata = win_rdata;
    end

    assign table_mode = table_q;
    assign vec_flat   = vec_q;
    assign mask_vec   = mask_q;

    AST_SEL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_wr) |-> sel_q == $past(bus_wdata[IDX_W-1:0])); // R1
    AST_VERSION_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_WINDOW) && sel_q == IDX_VERSION) |-> bus_rdata == 32'h0017_0011 || NUM_IRQ != 24); // R4
endmodule

// File: rtl/irq_arbiter.sv
// Combinational picker: among eligible lines, chooses the highest class
// (vector[7:4]) in table mode, or the lowest line in legacy mode; ties
// resolve to the lowest line. Assumes vec_flat holds NUM_IRQ packed bytes.
module irq_arbiter
    import irq_router_pkg::*;
#(
    parameter int NUM_IRQ = 24,
    localparam int IW     = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]       eligible,
    input  logic                     table_mode,
    input  logic [NUM_IRQ*VEC_W-1:0] vec_flat,
    output logic                     any,
    output logic [IW-1:0]            win_idx,
    output logic [VEC_W-1:0]         win_vec,
    output logic [PRIO_W-1:0]        win_prio
);
    logic [PRIO_W-1:0] best_key;
    logic [PRIO_W-1:0] key;

    // Scan lines upward; only a strictly larger class replaces the holder.
    always_comb begin
        any      = 1'b0;
        best_key = '0;
        win_idx  = '0;
        for (int n = 0; n < NUM_IRQ; n++) begin
            key = table_mode ? vec_flat[n*VEC_W+4 +: PRIO_W] : '0;
            if (eligible[n] && (!any || key > best_key)) begin
                any      = 1'b1;
                best_key = key;
                win_idx  = IW'(n);
            end
        end
    end

    // Vector of the chosen line, table-driven or fixed offset.
    always_comb begin
        win_vec  = table_mode ? vec_flat[win_idx*VEC_W +: VEC_W] : LEGACY_BASE + VEC_W'(win_idx);
        win_prio = win_vec[7:4];
    end

    // Winner must be one of the eligible lines.
    always_comb begin
        if (any) begin
            AST_WIN_ELIGIBLE: assert (eligible[win_idx]); // R6
        end
    end
endmodule

// File: rtl/irq_router.sv
// Top of the redirection controller: register bank, arbiter, and a
// registered valid/ready delivery stage with per-line service tracking.
// Assumes level-sensitive requests synchronous to clk.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_IRQ = 24,
    parameter int ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_IRQ-1:0] irq_in,
    output logic               dlv_valid,
    input  logic               dlv_ready,
    output logic [7:0]         dlv_vector,
    output logic [3:0]         dlv_prio
);
    localparam int IW = $clog2(NUM_IRQ);

    logic                     table_mode;
    logic [NUM_IRQ*VEC_W-1:0] vec_flat;
    logic [NUM_IRQ-1:0]       mask_vec;
    logic [NUM_IRQ-1:0]       eligible;
    logic [NUM_IRQ-1:0]       served_q;
    logic [NUM_IRQ-1:0]       taken;
    logic                     any;
    logic [IW-1:0]            win_idx;
    logic [VEC_W-1:0]         win_vec;
    logic [PRIO_W-1:0]        win_prio;
    logic                     valid_q;
    logic [VEC_W-1:0]         vec_q;
    logic [PRIO_W-1:0]        prio_q;
    logic [IW-1:0]            cur_q;
    logic                     accept;

    irq_regbank #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .table_mode(table_mode),
        .vec_flat(vec_flat), .mask_vec(mask_vec)
    );

    assign eligible = irq_in & ~served_q & (table_mode ? ~mask_vec : {NUM_IRQ{1'b1}});
    assign accept   = valid_q && dlv_ready;
    assign taken    = accept ? (NUM_IRQ'(1) << cur_q) : '0;

    irq_arbiter #(.NUM_IRQ(NUM_IRQ)) u_arb (
        .eligible(eligible), .table_mode(table_mode), .vec_flat(vec_flat),
        .any(any), .win_idx(win_idx), .win_vec(win_vec), .win_prio(win_prio)
    );

    // Service flags: set on acceptance, cleared while the line is low.
    always_ff @(posedge clk) begin
        if (!rst_n) served_q <= '0;
        else        served_q <= (served_q | taken) & irq_in;
    end

    // Delivery stage: load a winner when idle, hold until accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            vec_q   <= '0;
            prio_q  <= '0;
            cur_q   <= '0;
        end else if (valid_q) begin
            if (accept) valid_q <= 1'b0;
        end else if (any) begin
            valid_q <= 1'b1;
            vec_q   <= win_vec;
            prio_q  <= win_prio;
            cur_q   <= win_idx;
        end
    end

    assign dlv_valid  = valid_q;
    assign dlv_vector = vec_q;
    assign dlv_prio   = prio_q;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_vector) && $stable(dlv_prio)); // R9
    AST_GAP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid && dlv_ready |=> !dlv_valid); // R9
    AST_NOT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> !served_q[cur_q]); // R10
    AST_PRIO_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> dlv_prio == dlv_vector[7:4]); // R7
    AST_LEGACY_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dlv_valid) && !$past(table_mode) |-> dlv_vector == LEGACY_BASE + VEC_W'(cur_q)); // R8
endmodule

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;
    localparam int N = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] irq_in = '0;
    logic        dlv_valid;
    logic        dlv_ready = 1'b1;
    logic [7:0]  dlv_vector;
    logic [3:0]  dlv_prio;

    always #4 clk = ~clk;

    irq_router dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_vector(dlv_vector),
        .dlv_prio(dlv_prio)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string phase = "R3";

    // Behavioural reference state.
    int       m_sel;
    bit       m_mode;
    bit [3:0] m_id;
    bit [7:0] m_vec [N];
    bit       m_mask [N];
    bit       m_served [N];
    bit       m_valid;
    bit [7:0] m_vout;
    int       m_cur;

    function automatic bit [31:0] model_read(bit [4:0] a);
        if (a == 5'h00) return 32'(m_sel);
        if (a != 5'h10) return 0;
        if (m_sel == 0) return {4'b0, m_id, 23'b0, m_mode};
        if (m_sel == 1) return 32'h0017_0011;
        if (m_sel == 2) return {4'b0, m_id, 24'b0};
        if (m_sel >= 16 && m_sel < 16 + 2 * N && (m_sel % 2) == 0)
            return {15'b0, m_mask[(m_sel - 16) / 2], 8'b0, m_vec[(m_sel - 16) / 2]};
        return 0;
    endfunction

    task automatic model_step();
        bit acc;
        int best, bk, key;
        if (!rst_n) begin
            m_sel = 0; m_mode = 0; m_id = 0; m_valid = 0; m_vout = 0; m_cur = 0;
            for (int n = 0; n < N; n++) begin m_vec[n] = 0; m_mask[n] = 1; m_served[n] = 0; end
            return;
        end
        acc = m_valid && dlv_ready;
        best = -1; bk = -1;
        for (int n = 0; n < N; n++) begin
            key = m_mode ? int'(m_vec[n] >> 4) : 0;
            if (irq_in[n] && !m_served[n] && (!m_mode || !m_mask[n]) && key > bk) begin
                bk = key; best = n;
            end
        end
        for (int n = 0; n < N; n++)
            m_served[n] = (m_served[n] || (acc && n == m_cur)) && irq_in[n];
        if (m_valid) begin
            if (acc) m_valid = 0;
        end else if (best >= 0) begin
            m_valid = 1; m_cur = best;
            m_vout = m_mode ? m_vec[best] : 8'(8'h30 + best);
        end
        if (bus_wr && bus_addr == 5'h00) m_sel = int'(bus_wdata[7:0]);
        if (bus_wr && bus_addr == 5'h10) begin
            if (m_sel == 0) begin m_id = bus_wdata[27:24]; m_mode = bus_wdata[0]; end
            if (m_sel >= 16 && m_sel < 16 + 2 * N && (m_sel % 2) == 0) begin
                m_vec[(m_sel - 16) / 2]  = bus_wdata[7:0];
                m_mask[(m_sel - 16) / 2] = bus_wdata[16];
            end
        end
    endtask

    task automatic chk(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", phase, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("rdata", int'(bus_rdata), int'(model_read(bus_addr)));
        chk("valid", int'(dlv_valid), int'(m_valid));
        if (m_valid) begin
            chk("vector", int'(dlv_vector), int'(m_vout));
            chk("prio", int'(dlv_prio), int'(m_vout >> 4));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        if (rst_n) compare();
    endtask

    task automatic ticks(int k);
        for (int i = 0; i < k; i++) tick();
    endtask

    task automatic bus_write(bit [4:0] a, bit [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic read_at(bit [4:0] a);
        bus_addr = a;
        tick();
    endtask

    task automatic win_read(int idx);
        bus_write(5'h00, 32'(idx));
        read_at(5'h10);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        #(8 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        ticks(3);
        rst_n = 1'b1;
        tick();
        // R3: identification word resets to legacy mode, ID 0
        phase = "R3"; win_read(0);
        // R4: version word
        phase = "R4"; win_read(1);
        bus_write(5'h10, 32'hFFFF_FFFF); read_at(5'h10);
        // R5: entry reset state and empty high half
        phase = "R5"; win_read(16); win_read(17);
        bus_write(5'h10, 32'hFFFF_FFFF); read_at(5'h10);
        win_read(5); bus_write(5'h10, 32'h0001_00AA); read_at(5'h10);
        // R1: index register capture and readback
        phase = "R1"; bus_write(5'h00, 32'hABCD_122A); read_at(5'h00);
        // R2: stray offset ignores writes, reads zero
        phase = "R2"; bus_write(5'h04, 32'hFFFF_FFFF); read_at(5'h04);
        win_read(16);
        // R8: legacy delivery in line order, masks ignored
        phase = "R8"; irq_in = (N'(1) << 20) | (N'(1) << 5) | (N'(1) << 2);
        ticks(8);
        // R10: a served line returns only after a low-high cycle
        phase = "R10"; ticks(3);
        irq_in[5] = 1'b0; tick(); irq_in[5] = 1'b1; ticks(4);
        // R9: back-pressure holds the offered vector
        phase = "R9"; dlv_ready = 1'b0; irq_in[9] = 1'b1; ticks(6);
        dlv_ready = 1'b1; ticks(3);
        irq_in = '0; ticks(2);
        // R3: switch to table mode and set ID
        phase = "R3"; win_read(0); bus_write(5'h10, 32'h0500_0001); read_at(5'h10);
        win_read(2); bus_write(5'h10, 32'h0A00_0000); read_at(5'h10);
        // R6: program vectors and masks
        phase = "R6";
        bus_write(5'h00, 32'h16); bus_write(5'h10, 32'h0000_0091);
        bus_write(5'h00, 32'h1E); bus_write(5'h10, 32'h0000_0095);
        bus_write(5'h00, 32'h24); bus_write(5'h10, 32'h0000_00E0);
        bus_write(5'h00, 32'h28); bus_write(5'h10, 32'h0001_00F0);
        read_at(5'h10);
        // R7: class order and tie to lower line; R11 latency
        phase = "R7"; irq_in = (N'(1) << 3) | (N'(1) << 7) | (N'(1) << 10) | (N'(1) << 12);
        ticks(2);
        phase = "R11"; ticks(8);
        // R6: unmasking a pending line lets it through
        phase = "R6"; bus_write(5'h10, 32'h0000_00F0); ticks(4);
        // R9: hold in table mode
        phase = "R9"; dlv_ready = 1'b0; irq_in[3] = 1'b0; tick(); irq_in[3] = 1'b1; ticks(4);
        dlv_ready = 1'b1; ticks(3);
        // R8: back to legacy with a masked line pending
        phase = "R8"; irq_in = '0; ticks(2);
        bus_write(5'h00, 32'h0); bus_write(5'h10, 32'h0);
        irq_in[23] = 1'b1; irq_in[0] = 1'b1; ticks(6);
        irq_in = '0; ticks(2);
        finish_run();
    end
endmodule